// File: doc/BRIEF.md
# Streaming Monobit Randomness Tester

This block judges whether a noise source produces a balanced mix of ones and zeros. The source streams 16-bit words. The block takes 1250 of them, which is a 20,000-bit sample, and counts the ones in each word as it arrives. It never holds the sample itself. When the last word of a sample has been taken, the block raises a one-cycle verdict strobe and a pass flag. The pass flag is high when the total ones count lies inside the acceptance window. A new sample then begins from a cleared count.

The input is a valid/ready stream. The source holds `sample_valid` high with a word on `sample_word`. A word is taken on a rising clock edge only when `sample_valid` and `sample_ready` are both high. `sample_ready` is low only during the single verdict cycle, which is the block's only back-pressure. A word offered in that cycle stays pending and is not counted. A source that lowers `sample_valid` in mid-sample pauses collection, and the partial count is kept. Because only a count is kept, the order of bits inside a word and the order of the words have no effect on the verdict.

Top module: `mbt_monobit_tester`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after it, `running`, `done` and `pass` are low and `sample_ready` is high. Reset also clears the word count and the ones total.
- R2: A word is accepted at a rising edge exactly when `sample_valid` and `sample_ready` are both high. `sample_ready` is high in every cycle except the verdict cycle.
- R3: A sample is exactly 1250 accepted words. `done` is high for exactly one cycle, which is the cycle that follows the edge at which the 1250th word of the sample is accepted.
- R4: In the `done` cycle, `pass` is 1 when the sample's total ones count T satisfies 9725 < T < 10275, and 0 otherwise. Outside the `done` cycle, `pass` is 0.
- R5: `running` rises in the cycle after the first accepted word of a sample. It stays high until the edge that accepts the 1250th word, and it is low in the `done` cycle.
- R6: A cycle with `sample_valid` low changes nothing: `running` holds and the partial count is kept, so a paused sample's verdict equals that of an unpaused one.
- R7: A word offered during the `done` cycle is not accepted and does not count toward the next sample.
- R8: After a verdict, the next sample starts from a ones total and a word count of zero.
- R9: Each word contributes the number of its 16 bits that are 1, whatever their positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Source has a noise word on `sample_word` |
| sample_ready | output | 1 | Block can take a word this cycle (low only in the verdict cycle) |
| sample_word | input | 16 | Noise word |
| running | output | 1 | A sample is partly collected |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Ones count inside the acceptance window (valid while `done` is high) |

## Verification
The assertions check the following on every cycle. `done` is a single-cycle pulse. `pass` never appears without `done`. `running` falls exactly at the verdict and rises only after an accepted word. A cycle without an accepted word leaves `running` unchanged. The outputs are idle straight after reset. Only the bench's scenarios can show that a verdict arrives after exactly 1250 words, and that the window edges 9725 and 10275 fail while 9726 and 10274 pass. The scenarios also show that a paused sample keeps its count, that a word offered in the verdict cycle is not taken, and that bit positions do not matter.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam int unsigned MBT_WORD_W      = 16;
  localparam int unsigned MBT_SAMPLE_BITS = 20000;
  localparam int unsigned MBT_PASS_LO     = 9725;
  localparam int unsigned MBT_PASS_HI     = 10275;

  function automatic logic in_window(input int unsigned total,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (total > lo) && (total < hi);
  endfunction
endpackage

// File: rtl/mbt_popcount.sv
module mbt_popcount #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CW = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  output logic [CW-1:0]     ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < WORD_W; i++) begin
      ones = ones + CW'(word[i]);
    end
  end
endmodule

// File: rtl/mbt_word_ctr.sv
module mbt_word_ctr #(
  parameter int unsigned NWORDS = 1250,
  localparam int unsigned CNT_W = $clog2(NWORDS)
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == CNT_W'(NWORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (last) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mbt_ones_acc.sv
module mbt_ones_acc
  import mbt_pkg::*;
#(
  parameter int unsigned PC_W    = 5,
  parameter int unsigned ONES_W  = 15,
  parameter int unsigned PASS_LO = 9725,
  parameter int unsigned PASS_HI = 10275
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            last,
  input  logic [PC_W-1:0] word_ones,
  output logic            running,
  output logic            done,
  output logic            pass
);
  logic [ONES_W-1:0] acc_q;
  logic [ONES_W-1:0] total_next;

  assign total_next = acc_q + ONES_W'(word_ones);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      running <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      done <= adv && last;
      pass <= adv && last && in_window(int'(total_next), PASS_LO, PASS_HI);
      if (adv) begin
        if (last) begin
          acc_q   <= '0;
          running <= 1'b0;
        end else begin
          acc_q   <= total_next;
          running <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mbt_monobit_tester.sv
module mbt_monobit_tester
  import mbt_pkg::*;
#(
  parameter int unsigned WORD_W      = MBT_WORD_W,
  parameter int unsigned SAMPLE_BITS = MBT_SAMPLE_BITS,
  parameter int unsigned PASS_LO     = MBT_PASS_LO,
  parameter int unsigned PASS_HI     = MBT_PASS_HI
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  output logic              sample_ready,
  input  logic [WORD_W-1:0] sample_word,
  output logic              running,
  output logic              done,
  output logic              pass
);
  localparam int unsigned NWORDS = SAMPLE_BITS / WORD_W;
  localparam int unsigned PC_W   = $clog2(WORD_W + 1);
  localparam int unsigned ONES_W = $clog2(SAMPLE_BITS + 1);

  logic            adv;
  logic            last;
  logic [PC_W-1:0] word_ones;

  // the verdict cycle is the only cycle that applies back-pressure
  assign sample_ready = ~done;
  assign adv          = sample_valid & sample_ready;

  mbt_popcount #(.WORD_W(WORD_W)) u_pop (
    .word (sample_word),
    .ones (word_ones)
  );

  mbt_word_ctr #(.NWORDS(NWORDS)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv),
    .last (last)
  );

  mbt_ones_acc #(
    .PC_W    (PC_W),
    .ONES_W  (ONES_W),
    .PASS_LO (PASS_LO),
    .PASS_HI (PASS_HI)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .last      (last),
    .word_ones (word_ones),
    .running   (running),
    .done      (done),
    .pass      (pass)
  );
endmodule

// File: rtl/mbt_monobit_checker.sv
module mbt_monobit_checker (
  input logic clk,
  input logic rst,
  input logic sample_valid,
  input logic sample_ready,
  input logic running,
  input logic done,
  input logic pass
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!running && !done && !pass && sample_ready));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_pass_in_done_R4: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);

  assert_idle_at_verdict_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !running);

  assert_fall_at_verdict_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> done);

  assert_rise_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(sample_valid && sample_ready));

  assert_pause_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(sample_valid && sample_ready) |=> $stable(running));
endmodule

bind mbt_monobit_tester mbt_monobit_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_valid (sample_valid),
  .sample_ready (sample_ready),
  .running      (running),
  .done         (done),
  .pass         (pass)
);

// File: tb/mbt_monobit_tester_tb.sv
module mbt_monobit_tester_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 1250;
  localparam int LO = 9725;
  localparam int HI = 10275;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic sample_ready;
  logic [15:0] sample_word = '0;
  logic running, done, pass;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit compare_on = 0;

  // reference model state
  int  m_words = 0;
  int  m_ones = 0;
  bit  m_running = 0;
  bit  m_done = 0;
  bit  m_pass = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbt_monobit_tester u_dut (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .sample_ready (sample_ready),
    .sample_word  (sample_word),
    .running      (running),
    .done         (done),
    .pass         (pass)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model, updated at every rising edge
  always @(posedge clk) begin
    bit take;
    bit d_n, p_n;
    if (rst) begin
      m_words = 0; m_ones = 0; m_running = 0; m_done = 0; m_pass = 0;
    end else begin
      take = sample_valid && !m_done;
      d_n = 0; p_n = 0;
      if (take) begin
        m_ones += $countones(sample_word);
        m_words++;
        if (m_words == NW) begin
          d_n = 1;
          p_n = (m_ones > LO) && (m_ones < HI);
          m_words = 0; m_ones = 0; m_running = 0;
        end else begin
          m_running = 1;
        end
      end
      m_done = d_n;
      m_pass = p_n;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (compare_on && !finished) begin
      check("R2", "sample_ready", int'(sample_ready), int'(!m_done));
      check("R3", "done", int'(done), int'(m_done));
      check("R4", "pass", int'(pass), int'(m_pass));
      check("R5", "running", int'(running), int'(m_running));
    end
  end

  function automatic logic [15:0] make_word(input int p, input int rot);
    logic [31:0] m;
    logic [15:0] w;
    m = (p >= 16) ? 32'hFFFF : ((32'd1 << p) - 1);
    w = m[15:0];
    return (w << rot) | (w >> (16 - rot));
  endfunction

  // drives one sample whose total ones count is target
  task automatic run_sample(input int target, input int pause_at, input string tag);
    int remaining = target;
    int p;
    for (int i = 0; i < NW; i++) begin
      if (i == pause_at) begin
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          sample_valid = 1'b0;
          sample_word = 16'hFFFF;
        end
        @(negedge clk);
        check("R6", "running held in pause", int'(running), 1);
        check("R6", "no verdict in pause", int'(done), 0);
      end else begin
        @(negedge clk);
      end
      p = (remaining + (NW - i) / 2) / (NW - i);
      if (p > 16) p = 16;
      if (p > remaining) p = remaining;
      remaining -= p;
      sample_valid = 1'b1;
      sample_word = make_word(p, i % 16); // R9: ones at rotating positions
    end
    @(negedge clk);
    check(tag, "verdict strobe", int'(done), 1);
    check(tag, "verdict pass", int'(pass), int'((target > LO) && (target < HI)));
    // R7: offer an all-ones word during the verdict cycle
    sample_valid = 1'b1;
    sample_word = 16'hFFFF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "running after reset", int'(running), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "pass after reset", int'(pass), 0);
    check("R1", "ready after reset", int'(sample_ready), 1);
    compare_on = 1;
    run_sample(10000, 600, "R6");
    run_sample(9725, -1, "R7");
    run_sample(9726, -1, "R8");
    run_sample(10274, 3, "R4");
    run_sample(10275, -1, "R4");
    run_sample(15000, -1, "R9");
    run_sample(0, -1, "R3");
    @(negedge clk);
    sample_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R3", "no extra verdict", int'(done), 0);
    check("R5", "idle after last sample", int'(running), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule